// File: doc/BRIEF.md
# Streaming Hamming ECC Accumulator

This block builds a single-error-correcting Hamming parity word over a byte stream, one word per chunk of 256 accepted bytes. A byte is taken on every rising clock edge where the valid strobe is high. When the 256th byte of a chunk is taken, the finished parity is latched into a result register and a one-cycle result-valid pulse follows. Accumulation then restarts with no idle cycle, so a byte presented on the very next cycle opens the next chunk. A clear input empties the accumulator and the byte counter at any moment, which is how a new transfer is started.

Next to the latched result, the block drives the 24-bit spare-area form of that result: three bytes that a flash controller stores alongside each chunk. A separate combinational checker takes a stored code and a freshly computed one and reports whether they match, whether a single data bit flipped (with its byte and bit position), whether the code itself took a single-bit hit, or whether the damage cannot be corrected.

Top module: `hamming_chunk_acc`

## Requirements
- R1: After a synchronous reset, `res_valid` is 0, `res_parity` is 0 and `res_code` is 24'hFFFFFF.
- R2: Column parity sits in `res_parity[5:0]`: for bit group g in 0..2, bit 2g is the XOR of all chunk data bits whose bit position has bit g clear, and bit 2g+1 the XOR of those with bit g set.
- R3: Line parity sits in `res_parity[20:6]`: for byte-index bit k in 0..6, bit 6+2k is the XOR of all data bits in bytes whose index (0..255 within the chunk) has bit k clear, and bit 7+2k the XOR of those with bit k set; bit 20 is the XOR of all bits in bytes with index bit 7 set (the even member of that pair is folded away).
- R4: A chunk is 256 bytes taken with `in_valid` high; cycles with `in_valid` low are ignored. The result is latched at the edge taking the 256th byte and `res_valid` is high for exactly the cycle after that edge; `res_parity` changes at no other time.
- R5: Chunks may stream back to back: the byte taken one cycle after the 256th is byte 0 of the next chunk and nothing is lost.
- R6: `clr` high at an edge empties the accumulator and byte count; a byte presented together with `clr` is discarded, no `res_valid` follows, and `res_parity` keeps its value.
- R7: `res_code` equals the bitwise inverse of `{1'b0, res_parity, 2'b00}`; byte `res_code[23:16]` is written to the spare area first, then `[15:8]`, then `[7:0]`.
- R8: When `chk_stored` equals `chk_calc`, `chk_status` is 0 (no error).
- R9: When the two codes differ exactly by one data bit flip in byte i, bit j, `chk_status` is 1, `chk_byte` is i and `chk_bit` is j.
- R10: When the two codes differ in exactly one of their 24 bits, `chk_status` is 2 (the code itself is damaged).
- R11: Any other difference gives `chk_status` 3 (uncorrectable); `chk_byte` and `chk_bit` are 0 whenever `chk_status` is not 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Empties accumulator and byte count |
| in_valid | input | 1 | Byte strobe |
| in_data | input | 8 | Data byte |
| res_valid | output | 1 | One-cycle pulse after a chunk completes |
| res_parity | output | 21 | Latched parity: line in [20:6], column in [5:0] |
| res_code | output | 24 | Spare-area code of the latched parity, first byte in [23:16] |
| chk_stored | input | 24 | Code read back from the spare area |
| chk_calc | input | 24 | Code recomputed from the read data |
| chk_status | output | 2 | 0 none, 1 data bit correctable, 2 code bit, 3 uncorrectable |
| chk_byte | output | 8 | Byte index of the correctable error |
| chk_bit | output | 3 | Bit index of the correctable error |

## Verification
The parity word and its code are due one cycle after the edge that takes the 256th byte, so the bench drives bytes on falling edges and samples one nanosecond after that rising edge, then samples again a cycle later to see the pulse gone. A clear is checked the same way, one edge after it is applied. The checker is combinational, so each syndrome pattern is applied and read after a one-nanosecond settle, with every single data-bit position of a chunk swept exhaustively against expected indices computed from the parity layout.

// File: rtl/hamming_chunk_acc.sv
module hamming_chunk_acc (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        res_valid,
  output logic [20:0] res_parity,
  output logic [23:0] res_code,
  input  logic [23:0] chk_stored,
  input  logic [23:0] chk_calc,
  output logic [1:0]  chk_status,
  output logic [7:0]  chk_byte,
  output logic [2:0]  chk_bit
);
  localparam int IDX_W  = 8;
  localparam int COL_W  = 6;
  localparam int LINE_W = 2 * IDX_W - 1;
  localparam int CODE_W = 24;

  logic [IDX_W-1:0]  cnt;
  logic [COL_W-1:0]  col_acc, col_nxt;
  logic [LINE_W-1:0] line_acc, line_nxt;

  wire byte_par = ^in_data;
  wire take     = in_valid & ~clr;
  wire last     = take & (cnt == {IDX_W{1'b1}});

  assign col_nxt = col_acc ^ {^(in_data & 8'hF0), ^(in_data & 8'h0F),
                              ^(in_data & 8'hCC), ^(in_data & 8'h33),
                              ^(in_data & 8'hAA), ^(in_data & 8'h55)};

  always_comb begin
    line_nxt = line_acc;
    for (int k = 0; k < IDX_W - 1; k++) begin
      line_nxt[2*k]   = line_acc[2*k]   ^ (byte_par & ~cnt[k]);
      line_nxt[2*k+1] = line_acc[2*k+1] ^ (byte_par &  cnt[k]);
    end
    line_nxt[LINE_W-1] = line_acc[LINE_W-1] ^ (byte_par & cnt[IDX_W-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      col_acc    <= '0;
      line_acc   <= '0;
      res_valid  <= 1'b0;
      res_parity <= '0;
    end else begin
      res_valid <= last;
      if (clr) begin
        cnt      <= '0;
        col_acc  <= '0;
        line_acc <= '0;
      end else if (take) begin
        cnt <= cnt + 1'b1;
        if (last) begin
          res_parity <= {line_nxt, col_nxt};
          col_acc    <= '0;
          line_acc   <= '0;
        end else begin
          col_acc  <= col_nxt;
          line_acc <= line_nxt;
        end
      end
    end
  end

  assign res_code = ~{1'b0, res_parity, 2'b00};

  // checker: syndrome of stored versus recomputed code
  logic [CODE_W-1:0] diff;
  logic [20:0]       syn;
  logic              pairs_single;

  assign diff = chk_stored ^ chk_calc;
  assign syn  = diff[22:2];

  always_comb begin
    pairs_single = (diff[23] == 1'b0) && (diff[1:0] == 2'b00);
    for (int p = 0; p < 10; p++)
      pairs_single = pairs_single & (syn[2*p] ^ syn[2*p+1]);
  end

  always_comb begin
    chk_status = 2'd3;
    chk_byte   = '0;
    chk_bit    = '0;
    if (diff == '0) begin
      chk_status = 2'd0;
    end else if ($countones(diff) == 1) begin
      chk_status = 2'd2;
    end else if (pairs_single) begin
      chk_status = 2'd1;
      chk_byte   = {syn[20], syn[19], syn[17], syn[15], syn[13], syn[11], syn[9], syn[7]};
      chk_bit    = {syn[5], syn[3], syn[1]};
    end
  end

  always_comb begin
    if (chk_status == 2'd1) begin
      assert_corr_weight_R9: assert ($countones(diff) >= 10 && $countones(diff) <= 11);
    end
    if (chk_status != 2'd1) begin
      assert_idx_zero_R11: assert (chk_byte == 8'd0 && chk_bit == 3'd0);
    end
  end

  assert_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  assert_latch_R4: assert property (@(posedge clk) disable iff (rst)
    !last |=> (!res_valid && $stable(res_parity)));
  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == 8'd0 && col_acc == 6'd0 && line_acc == 15'd0));
  assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
    last |=> (cnt == 8'd0 && col_acc == 6'd0 && line_acc == 15'd0));
endmodule

// File: tb/hamming_chunk_acc_test.sv
`timescale 1ns/1ps
module hamming_chunk_acc_test;
  logic        clk = 1'b0;
  logic        rst, clr, in_valid;
  logic [7:0]  in_data;
  logic        res_valid;
  logic [20:0] res_parity;
  logic [23:0] res_code;
  logic [23:0] chk_stored, chk_calc;
  logic [1:0]  chk_status;
  logic [7:0]  chk_byte;
  logic [2:0]  chk_bit;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] mem [256];

  always #2.5 clk = ~clk;

  hamming_chunk_acc uut (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_data(in_data),
    .res_valid(res_valid), .res_parity(res_parity), .res_code(res_code),
    .chk_stored(chk_stored), .chk_calc(chk_calc), .chk_status(chk_status),
    .chk_byte(chk_byte), .chk_bit(chk_bit));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // parity bits a single set data bit (byte i, bit j) contributes
  function automatic logic [20:0] bit_pattern(input int i, input int j);
    logic [20:0] p = '0;
    for (int g = 0; g < 3; g++) p[2*g + ((j >> g) & 1)] = 1'b1;
    for (int k = 0; k < 7; k++) p[6 + 2*k + ((i >> k) & 1)] = 1'b1;
    if (i >= 128) p[20] = 1'b1;
    return p;
  endfunction

  function automatic logic [20:0] chunk_parity();
    logic [20:0] p = '0;
    for (int n = 0; n < 256; n++)
      for (int b = 0; b < 8; b++)
        if (mem[n][b]) p = p ^ bit_pattern(n, b);
    return p;
  endfunction

  function automatic logic [23:0] to_code(input logic [20:0] p);
    return ~{1'b0, p, 2'b00};
  endfunction

  task automatic fill(input int seed);
    for (int n = 0; n < 256; n++)
      mem[n] = 8'(((n * 37 + seed * 11) ^ (n >> 3) ^ (seed << 4)) & 255);
  endtask

  task automatic stream(input bit gap, input string tag);
    logic [20:0] exp = chunk_parity();
    for (int n = 0; n < 256; n++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = mem[n];
      if (gap && n != 255) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = ~mem[n];
      end
    end
    @(posedge clk);
    #1;
    check({tag, " R4 res_valid"}, 32'(res_valid), 32'd1);
    check({tag, " R2 R3 parity"}, 32'(res_parity), 32'(exp));
    check({tag, " R7 code"}, 32'(res_code), 32'(to_code(exp)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [20:0] held;
    logic [23:0] base;
    rst = 1'b1; clr = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    chk_stored = '0; chk_calc = '0;
    repeat (3) @(negedge clk);
    check("R1 res_valid", 32'(res_valid), 32'd0);
    check("R1 res_parity", 32'(res_parity), 32'd0);
    check("R1 res_code", 32'(res_code), 32'hFFFFFF);
    rst = 1'b0;

    // single set bit: byte 200, bit 5
    for (int n = 0; n < 256; n++) mem[n] = 8'h00;
    mem[200] = 8'h20;
    stream(1'b0, "single-bit");
    check("R2 R3 single-bit layout", 32'(res_parity), 32'(bit_pattern(200, 5)));

    // R5: two chunks back to back, no idle cycle
    fill(1);
    stream(1'b0, "chunkA");
    fill(2);
    stream(1'b0, "chunkB R5");
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    check("R4 pulse one cycle", 32'(res_valid), 32'd0);

    // R4: bubbles with garbage data are ignored
    fill(3);
    stream(1'b1, "gapped R4");

    // all-ones and all-zero chunks
    for (int n = 0; n < 256; n++) mem[n] = 8'hFF;
    stream(1'b0, "ones");
    for (int n = 0; n < 256; n++) mem[n] = 8'h00;
    stream(1'b0, "zeros R7");
    check("R7 first byte", 32'(res_code[23:16]), 32'hFF);

    // R6: clear mid-chunk, byte with clr is dropped
    fill(4);
    held = res_parity;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk); in_valid = 1'b1; in_data = mem[n];
    end
    @(negedge clk); clr = 1'b1; in_valid = 1'b1; in_data = 8'hA7;
    @(posedge clk); #1;
    check("R6 no pulse on clear", 32'(res_valid), 32'd0);
    check("R6 result held", 32'(res_parity), 32'(held));
    @(negedge clk); clr = 1'b0; in_valid = 1'b0;
    @(posedge clk); #1;
    check("R6 result held after", 32'(res_parity), 32'(held));
    fill(5);
    stream(1'b0, "after-clear R6");
    @(negedge clk); in_valid = 1'b0;

    // checker
    base = res_code;
    chk_stored = base; chk_calc = base; #1;
    check("R8 equal codes", 32'(chk_status), 32'd0);
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 8; j++) begin
        chk_calc = base ^ {1'b0, bit_pattern(i, j), 2'b00};
        #1;
        check("R9 data bit", {19'd0, chk_status, chk_byte, chk_bit},
              {19'd0, 2'd1, 8'(i), 3'(j)});
      end
    for (int q = 0; q < 24; q++) begin
      chk_calc = base ^ (24'd1 << q);
      #1;
      check("R10 code bit", {19'd0, chk_status, chk_byte, chk_bit}, {19'd0, 2'd2, 11'd0});
    end
    for (int j = 0; j < 7; j++) begin
      chk_calc = base ^ {1'b0, bit_pattern(0, j) ^ bit_pattern(0, j + 1), 2'b00};
      #1;
      check("R11 two bits one byte", {19'd0, chk_status, chk_byte, chk_bit}, {19'd0, 2'd3, 11'd0});
    end
    for (int i = 0; i < 255; i += 17) begin
      chk_calc = base ^ {1'b0, bit_pattern(i, 3) ^ bit_pattern(i + 1, 3), 2'b00};
      #1;
      check("R11 two bytes", {19'd0, chk_status, chk_byte, chk_bit}, {19'd0, 2'd3, 11'd0});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule